// File: doc/BRIEF.md
# Bridge Driver Fault Supervisor

This block gathers the protection conditions of a six-channel half-bridge output stage and decides which channels must be forced off and which status flags the host sees. Each channel supplies four comparator flags: overcurrent, under-load, thermal warning and thermal shutdown. The supply monitor supplies undervoltage and overvoltage flags. Two control bits from the command register select whether an expired under-load turns its channel off, and whether an overvoltage turns every output off.

Overcurrent is debounced by its own tick counter on each channel. Under-load is debounced by a single timer that all channels share. A channel that starts offending while that timer is already running only waits for the time that is left on it. Overcurrent, under-load and thermal shutdown are latched. Thermal warning and the supply-fail flag follow their inputs and clear by themselves. The latches are cleared by a status-reset strobe, by dropping the enable input, or by reset.

Every timer advances only on cycles where `tick` is high. Their lengths, counted in ticks, are parameters.

Top module: `fault_sup`

## Requirements
- R1: A low `rst_n`, or a low `en` sampled at a clock edge, clears every latch and timer. After that, `latch_off` is all zero and `st_oc`, `st_ul` and `st_tsd` are 0.
- R2: When `oc_raw[i]` stays high for OC_TICKS consecutive ticks, `latch_off[i]` and `st_oc` are set after the edge that samples the last of those ticks. If `oc_raw[i]` drops before then, that channel's count goes back to zero.
- R3: A `status_clr` issued while `oc_raw[i]` is still high clears the latch. The debounce then starts again from zero, and the channel latches again only after another full OC_TICKS ticks.
- R4: One under-load timer serves all channels. It runs while any channel has `ul_raw` high and is not yet latched. When it expires, every channel whose `ul_raw` is high at that moment is latched, including channels that joined partway through the count.
- R5: An expired under-load always sets `st_ul`, which then holds until it is cleared. The offending channel's bit in `latch_off` is set only when `ul_sd_en` = 1.
- R6: `st_tw` is the OR of `tw_raw`. It is not latched and never affects `latch_off`.
- R7: A high `tsd_raw[i]` latches `latch_off[i]` and `st_tsd` at the next edge. A `status_clr` has no effect on a channel whose `tsd_raw` is still high.
- R8: `st_psf` equals `uv | ov` and is not latched.
- R9: `supply_off` is 1 on undervoltage, and on overvoltage only when `ovlo_en` = 1. An overvoltage never changes `latch_off`.
- R10: A `status_clr` issued once no conditions remain clears `st_oc`, `st_ul`, `st_tsd` and all of `latch_off` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Device enable; low clears all state |
| tick | input | 1 | Timer time base, one-cycle pulse |
| oc_raw | input | NCH | Per-channel overcurrent comparator |
| ul_raw | input | NCH | Per-channel under-load comparator |
| tw_raw | input | NCH | Per-channel thermal warning |
| tsd_raw | input | NCH | Per-channel thermal shutdown |
| uv | input | 1 | Supply undervoltage |
| ov | input | 1 | Supply overvoltage |
| ul_sd_en | input | 1 | Expired under-load turns its channel off |
| ovlo_en | input | 1 | Overvoltage turns all outputs off |
| status_clr | input | 1 | Status-reset strobe from a valid command |
| latch_off | output | NCH | Per-channel forced-off request |
| supply_off | output | 1 | Global supply lockout |
| st_oc | output | 1 | Latched overcurrent status |
| st_ul | output | 1 | Latched under-load status |
| st_tsd | output | 1 | Latched thermal shutdown status |
| st_tw | output | 1 | Live thermal warning |
| st_psf | output | 1 | Live supply-fail status |

## Verification
The bench aims at the shared under-load timer. A second channel joins while the count is running and must latch on the same expiry as the first; a design with a timer per channel, or one that restarts the timer, would hold that channel on for too long. It issues a status reset while overcurrent is still present, which a design without a restarting counter would relatch at once. It also issues one while thermal shutdown is still present, which a naive design would clear. Finally, it checks that disabling overvoltage lockout leaves the outputs on while the supply-fail flag still reports, and that a short overcurrent glitch does not carry its partial count into the next one.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;
  typedef struct packed {
    logic oc;
    logic ul;
    logic tsd;
    logic tw;
    logic psf;
  } flags_t;
endpackage

// File: rtl/oc_debounce.sv
module oc_debounce #(
  parameter int TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic clr,
  input  logic tick,
  input  logic raw,
  output logic lat
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lat <= 1'b0;
    end else if (wipe || clr) begin
      cnt <= '0;
      lat <= 1'b0;
    end else if (!raw) begin
      cnt <= '0;
    end else if (tick && !lat) begin
      if (cnt == LAST) begin
        lat <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ul_shared_timer.sv
module ul_shared_timer #(
  parameter int NCH   = 6,
  parameter int TICKS = 350
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wipe,
  input  logic           clr,
  input  logic           tick,
  input  logic [NCH-1:0] pend,
  output logic           fire
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] tmr;
  logic          any_pend;

  assign any_pend = |pend;
  assign fire     = any_pend && tick && !wipe && !clr && (tmr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (wipe || clr || !any_pend || fire) begin
      tmr <= '0;
    end else if (tick) begin
      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/thermal_latch.sv
module thermal_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic clr,
  input  logic raw,
  output logic lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat <= 1'b0;
    else if (wipe)       lat <= 1'b0;
    else if (raw)        lat <= 1'b1;
    else if (clr)        lat <= 1'b0;
  end
endmodule

// File: rtl/fault_sup.sv
module fault_sup
  import fault_sup_pkg::*;
#(
  parameter int NCH      = 6,
  parameter int OC_TICKS = 25,
  parameter int UL_TICKS = 350
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic [NCH-1:0] oc_raw,
  input  logic [NCH-1:0] ul_raw,
  input  logic [NCH-1:0] tw_raw,
  input  logic [NCH-1:0] tsd_raw,
  input  logic           uv,
  input  logic           ov,
  input  logic           ul_sd_en,
  input  logic           ovlo_en,
  input  logic           status_clr,
  output logic [NCH-1:0] latch_off,
  output logic           supply_off,
  output logic           st_oc,
  output logic           st_ul,
  output logic           st_tsd,
  output logic           st_tw,
  output logic           st_psf
);
  logic           wipe;
  logic [NCH-1:0] oc_lat;
  logic [NCH-1:0] tsd_lat;
  logic [NCH-1:0] ul_lat;
  logic [NCH-1:0] ul_off;
  logic           ul_fire;
  flags_t         flags;

  assign wipe = !en;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    oc_debounce #(.TICKS(OC_TICKS)) u_oc (
      .clk(clk), .rst_n(rst_n), .wipe(wipe), .clr(status_clr),
      .tick(tick), .raw(oc_raw[g]), .lat(oc_lat[g])
    );
    thermal_latch u_tsd (
      .clk(clk), .rst_n(rst_n), .wipe(wipe), .clr(status_clr),
      .raw(tsd_raw[g]), .lat(tsd_lat[g])
    );
  end

  ul_shared_timer #(.NCH(NCH), .TICKS(UL_TICKS)) u_ul_tmr (
    .clk(clk), .rst_n(rst_n), .wipe(wipe), .clr(status_clr),
    .tick(tick), .pend(ul_raw & ~ul_lat), .fire(ul_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ul_lat <= '0;
      ul_off <= '0;
    end else if (wipe || status_clr) begin
      ul_lat <= '0;
      ul_off <= '0;
    end else if (ul_fire) begin
      ul_lat <= ul_lat | ul_raw;
      ul_off <= ul_off | (ul_raw & {NCH{ul_sd_en}});
    end
  end

  always_comb begin
    flags.oc  = |oc_lat;
    flags.ul  = |ul_lat;
    flags.tsd = |tsd_lat;
    flags.tw  = |tw_raw;
    flags.psf = uv | ov;
  end

  assign latch_off  = oc_lat | tsd_lat | ul_off;
  assign supply_off = uv | (ov & ovlo_en);
  assign st_oc      = flags.oc;
  assign st_ul      = flags.ul;
  assign st_tsd     = flags.tsd;
  assign st_tw      = flags.tw;
  assign st_psf     = flags.psf;
endmodule

// File: rtl/fault_sup_chk.sv
module fault_sup_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           status_clr,
  input logic [NCH-1:0] tsd_raw,
  input logic [NCH-1:0] latch_off,
  input logic           st_oc,
  input logic           st_ul,
  input logic           st_tsd
);
  // R1
  enable_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (latch_off == '0 && !st_oc && !st_ul && !st_tsd));

  // R2
  oc_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_oc) |-> (latch_off != '0));

  // R5
  ul_status_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ul && en && !status_clr) |=> st_ul);

  // R7
  tsd_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tsd_raw != '0) |=> st_tsd);

  // R10
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && status_clr && tsd_raw == '0) |=> (!st_oc && !st_ul && !st_tsd && latch_off == '0));
endmodule

bind fault_sup fault_sup_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .status_clr(status_clr),
  .tsd_raw(tsd_raw), .latch_off(latch_off),
  .st_oc(st_oc), .st_ul(st_ul), .st_tsd(st_tsd)
);

// File: tb/fault_sup_tb.sv
module fault_sup_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 6;
  localparam int OC_T = 4;
  localparam int UL_T = 10;

  logic clk = 1'b0;
  logic rst_n, en, tick, uv, ov, ul_sd_en, ovlo_en, status_clr;
  logic [NCH-1:0] oc_raw, ul_raw, tw_raw, tsd_raw, latch_off;
  logic supply_off, st_oc, st_ul, st_tsd, st_tw, st_psf;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_sup #(.NCH(NCH), .OC_TICKS(OC_T), .UL_TICKS(UL_T)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .oc_raw(oc_raw), .ul_raw(ul_raw), .tw_raw(tw_raw), .tsd_raw(tsd_raw),
    .uv(uv), .ov(ov), .ul_sd_en(ul_sd_en), .ovlo_en(ovlo_en),
    .status_clr(status_clr), .latch_off(latch_off), .supply_off(supply_off),
    .st_oc(st_oc), .st_ul(st_ul), .st_tsd(st_tsd), .st_tw(st_tw), .st_psf(st_psf)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick = 1'b1; step();
      tick = 1'b0; step();
    end
  endtask

  task automatic pulse_clr();
    status_clr = 1'b1; step();
    status_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset latch_off", latch_off, 0);
    check("R1 reset status", {st_oc, st_ul, st_tsd}, 0);
  endtask

  task automatic t_oc();
    oc_raw[2] = 1'b1;
    ticks(OC_T - 1);
    check("R2 oc before delay", latch_off, 0);
    ticks(1);
    check("R2 oc latch_off", latch_off, 6'b000100);
    check("R2 oc status", st_oc, 1);
  endtask

  task automatic t_oc_restart();
    pulse_clr();
    check("R3 clear with oc present", {st_oc, latch_off}, 0);
    ticks(OC_T - 1);
    check("R3 no early relatch", latch_off, 0);
    ticks(1);
    check("R3 relatch after full delay", latch_off, 6'b000100);
    oc_raw = '0;
    pulse_clr();
    check("R10 clear oc", {st_oc, latch_off}, 0);
  endtask

  task automatic t_oc_glitch();
    oc_raw[1] = 1'b1; ticks(OC_T - 1);
    oc_raw[1] = 1'b0; step();
    oc_raw[1] = 1'b1; ticks(OC_T - 1);
    check("R2 glitch count reset", {st_oc, latch_off}, 0);
    oc_raw = '0; step();
  endtask

  task automatic t_ul_shared();
    ul_sd_en = 1'b1;
    ul_raw[0] = 1'b1; ticks(6);
    ul_raw[3] = 1'b1; ticks(3);
    check("R4 before expiry", {st_ul, latch_off}, 0);
    ticks(1);
    check("R4 late joiner shares expiry", latch_off, 6'b001001);
    check("R5 ul status", st_ul, 1);
    ul_raw = '0; step();
    pulse_clr();
    check("R10 clear ul", {st_ul, latch_off}, 0);
  endtask

  task automatic t_ul_nosd();
    ul_sd_en = 1'b0;
    ul_raw[5] = 1'b1; ticks(UL_T);
    check("R5 status without shutdown", st_ul, 1);
    check("R5 no latch_off without shutdown", latch_off, 0);
    ul_raw = '0; step(2);
    check("R5 ul status latched", st_ul, 1);
    pulse_clr();
    check("R10 clear ul nosd", st_ul, 0);
  endtask

  task automatic t_tw();
    tw_raw = 6'b010000; step();
    check("R6 tw set", st_tw, 1);
    check("R6 tw no off", latch_off, 0);
    tw_raw = '0; step();
    check("R6 tw self clear", st_tw, 0);
  endtask

  task automatic t_tsd();
    tsd_raw[4] = 1'b1; step();
    check("R7 tsd latch", {st_tsd, latch_off}, {1'b1, 6'b010000});
    pulse_clr(); step();
    check("R7 clear ignored while hot", {st_tsd, latch_off}, {1'b1, 6'b010000});
    tsd_raw = '0; step(2);
    check("R7 stays latched", st_tsd, 1);
    pulse_clr();
    check("R10 clear tsd", {st_tsd, latch_off}, 0);
  endtask

  task automatic t_supply();
    uv = 1'b1; step();
    check("R8 uv psf", st_psf, 1);
    check("R9 uv off", supply_off, 1);
    uv = 1'b0; ov = 1'b1; ovlo_en = 1'b0; step();
    check("R8 ov psf", st_psf, 1);
    check("R9 ov no lockout", {supply_off, latch_off}, 0);
    ovlo_en = 1'b1; step();
    check("R9 ov lockout", supply_off, 1);
    check("R9 ov leaves latch_off", latch_off, 0);
    ov = 1'b0; step();
    check("R8 psf self clear", {st_psf, supply_off}, 0);
  endtask

  task automatic t_enable();
    oc_raw[0] = 1'b1; ticks(OC_T);
    check("R2 ch0 latch", latch_off, 6'b000001);
    oc_raw = '0;
    en = 1'b0; step();
    check("R1 enable low clears", {st_oc, latch_off}, 0);
    en = 1'b1; step();
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; tick = 1'b0; uv = 1'b0; ov = 1'b0;
    ul_sd_en = 1'b0; ovlo_en = 1'b0; status_clr = 1'b0;
    oc_raw = '0; ul_raw = '0; tw_raw = '0; tsd_raw = '0;
    step(3);
    rst_n = 1'b1; step();
    t_reset();
    t_oc();
    t_oc_restart();
    t_oc_glitch();
    t_ul_shared();
    t_ul_nosd();
    t_tw();
    t_tsd();
    t_supply();
    t_enable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule